// File: doc/BRIEF.md
# PHY Error and Event Counters

This block keeps three statistics counters for a 10/100 Ethernet PHY receive path. The first tallies link disconnect events. The second tallies false carrier events: carrier sense goes high, but no start-of-stream delimiter (the J/K symbol pair) is detected soon enough. The third tallies received packets that carried at least one receive error and saw no collision. The decoding logic upstream supplies all the event indications as single-bit, clock-synchronous signals.

Software reaches the counters through a small register port. A 2-bit address selects the counter, and the read data returns its value combinationally. A write strobe clears the counter at the selected address. The three counters handle their maximum differently. The disconnect counter wraps to zero. The false carrier counter and the packet error counter stop at all-ones.

Top module: `phy_evt_counters`

## Requirements
- R1: After reset, all three counters read zero.
- R2: Each clock cycle in which `link_drop` is high adds one to the disconnect counter (address 0). The new value is readable in the cycle after that edge.
- R3: The disconnect counter wraps from all-ones to zero.
- R4: A rising edge of `crs` starts a window of `CAR_WIN` cycles, with the rising cycle counted as the first. If `jk_seen` is not high in any cycle of the window, the false carrier counter (address 1) gains one in the last window cycle. The new value is readable `CAR_WIN` cycles after the rise and not before.
- R5: If `jk_seen` is high in any cycle of the window, including the rising cycle and the last cycle, nothing is counted.
- R6: The false carrier counter holds at all-ones instead of wrapping.
- R7: A packet is the run of cycles with `rx_dv` high. If `rx_er` is high in one or more of its cycles, the packet error counter (address 2) gains exactly one. The count is taken in the cycle where `pkt_end` is high together with `rx_dv`, on the packet's last data cycle.
- R8: The packet error counter does not change before `pkt_end`, even when errors have already been seen in the packet.
- R9: A packet in which `col` was high in any `rx_dv` cycle is not counted, whatever its errors.
- R10: The packet error counter holds at all-ones instead of wrapping.
- R11: A cycle with `reg_wr` high clears only the counter at `reg_addr`. A clear wins over an increment in the same cycle.
- R12: Address 0 reads the disconnect counter, 1 the false carrier counter, 2 the packet error counter, and 3 reads zero.
- R13: The per-packet error and collision flags restart at each rising edge of `rx_dv`. `rx_er` and `col` outside `rx_dv` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_drop | input | 1 | Disconnect event strobe, one count per high cycle |
| crs | input | 1 | Carrier sense level |
| jk_seen | input | 1 | Start-of-stream delimiter detected strobe |
| rx_dv | input | 1 | Receive data valid, high for the length of a packet |
| rx_er | input | 1 | Receive error indication |
| col | input | 1 | Collision indication |
| pkt_end | input | 1 | High on the last data cycle of a packet |
| reg_addr | input | 2 | Counter select |
| reg_wr | input | 1 | Clear strobe for the selected counter |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
A disconnect pulse and a counted packet end each show up on the read port one cycle after the edge that samples them. A false carrier shows up exactly `CAR_WIN` cycles after the carrier rise. The bench drives inputs just after the falling edge and reads just after the falling edge that follows the expected update edge. For the false carrier case it also reads one cycle early, to show that the count has not yet moved. Saturation and wrap are checked on a second instance with 4-bit counters and a 3-cycle window, which keeps the runs short.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;
  typedef enum logic [1:0] {
    CSEL_LINKDROP = 2'd0,
    CSEL_FALSECAR = 2'd1,
    CSEL_RXERR    = 2'd2,
    CSEL_NONE     = 2'd3
  } csel_e;

  localparam int unsigned NUM_CNT = 3;
endpackage

// File: rtl/evt_cnt.sv
module evt_cnt #(
  parameter int unsigned W        = 16,
  parameter bit          SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] val
);
  logic         en;
  logic [W-1:0] val_d;

  always_comb begin
    en    = inc | clr;
    val_d = val;
    if (clr) begin
      val_d = '0;
    end else if (inc) begin
      if (SATURATE && (val == {W{1'b1}})) val_d = val;
      else                                val_d = val + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  val <= '0;
    else if (en)  val <= val_d;
  end
endmodule

// File: rtl/false_car_det.sv
module false_car_det #(
  parameter int unsigned WIN = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic crs,
  input  logic jk_seen,
  output logic evt
);
  localparam int unsigned CW = (WIN < 2) ? 1 : $clog2(WIN + 1);

  logic          crs_q;
  logic          armed_q, armed_d;
  logic [CW-1:0] age_q, age_d;
  logic          rise;

  always_comb begin
    rise    = crs & ~crs_q;
    armed_d = armed_q;
    age_d   = age_q;
    evt     = 1'b0;
    if (armed_q) begin
      if (jk_seen) begin
        armed_d = 1'b0;
      end else if (age_q == CW'(WIN - 1)) begin
        evt     = 1'b1;
        armed_d = 1'b0;
      end else begin
        age_d = age_q + CW'(1);
      end
    end else if (rise && !jk_seen) begin
      if (WIN <= 1) begin
        evt = 1'b1;
      end else begin
        armed_d = 1'b1;
        age_d   = CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_q   <= 1'b0;
      armed_q <= 1'b0;
      age_q   <= '0;
    end else begin
      crs_q   <= crs;
      armed_q <= armed_d;
      age_q   <= age_d;
    end
  end
endmodule

// File: rtl/pkt_err_track.sv
module pkt_err_track (
  input  logic clk,
  input  logic rst_ni,
  input  logic rx_dv,
  input  logic rx_er,
  input  logic col,
  input  logic pkt_end,
  output logic evt
);
  logic dv_q, err_q, col_q;
  logic err_d, col_d;
  logic start, err_eff, col_eff;

  always_comb begin
    start   = rx_dv & ~dv_q;
    err_eff = (err_q & ~start) | (rx_dv & rx_er);
    col_eff = (col_q & ~start) | (rx_dv & col);
    err_d   = rx_dv ? err_eff : err_q;
    col_d   = rx_dv ? col_eff : col_q;
    evt     = pkt_end & rx_dv & err_eff & ~col_eff;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q  <= 1'b0;
      err_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      dv_q  <= rx_dv;
      err_q <= err_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/phy_evt_counters.sv
module phy_evt_counters
  import phy_evt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CAR_WIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_drop,
  input  logic             crs,
  input  logic             jk_seen,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             col,
  input  logic             pkt_end,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  output logic [CNT_W-1:0] rd_data
);
  logic rst_meta, rst_ni;
  logic fc_evt, rxe_evt;
  logic [NUM_CNT-1:0] inc_vec, clr_vec;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [CNT_W-1:0]   disc_cnt, fcar_cnt, rxe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ni, rst_meta} <= 2'b00;
    else        {rst_ni, rst_meta} <= {rst_meta, 1'b1};
  end

  false_car_det #(.WIN(CAR_WIN)) u_fcar (
    .clk(clk), .rst_ni(rst_ni), .crs(crs), .jk_seen(jk_seen), .evt(fc_evt)
  );

  pkt_err_track u_pkt (
    .clk(clk), .rst_ni(rst_ni), .rx_dv(rx_dv), .rx_er(rx_er),
    .col(col), .pkt_end(pkt_end), .evt(rxe_evt)
  );

  always_comb begin
    inc_vec = {rxe_evt, fc_evt, link_drop};
    for (int i = 0; i < NUM_CNT; i++) begin
      clr_vec[i] = reg_wr && (reg_addr == 2'(i));
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evt_cnt #(.W(CNT_W), .SATURATE(g != 0)) u_cnt (
      .clk(clk), .rst_ni(rst_ni), .inc(inc_vec[g]), .clr(clr_vec[g]),
      .val(cnt_q[g])
    );
  end

  assign disc_cnt = cnt_q[0];
  assign fcar_cnt = cnt_q[1];
  assign rxe_cnt  = cnt_q[2];

  always_comb begin
    unique case (csel_e'(reg_addr))
      CSEL_LINKDROP: rd_data = disc_cnt;
      CSEL_FALSECAR: rd_data = fcar_cnt;
      CSEL_RXERR:    rd_data = rxe_cnt;
      default:       rd_data = '0;
    endcase
  end
endmodule

// File: rtl/phy_evt_chk.sv
module phy_evt_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         link_drop,
  input logic         rx_dv,
  input logic         col,
  input logic         pkt_end,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] disc_val,
  input logic [W-1:0] fc_val,
  input logic [W-1:0] rxe_val
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic clr0, clr1, clr2;
  assign clr0 = reg_wr && (reg_addr == 2'd0);
  assign clr1 = reg_wr && (reg_addr == 2'd1);
  assign clr2 = reg_wr && (reg_addr == 2'd2);

  assert_disc_step_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    link_drop && !clr0 |=> disc_val == $past(disc_val) + ONE);

  assert_disc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    link_drop && !clr0 && disc_val == FULL |=> disc_val == '0);

  assert_fc_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    fc_val == FULL && !clr1 |=> fc_val == FULL);

  assert_rxe_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(pkt_end && rx_dv) && !clr2 |=> $stable(rxe_val));

  assert_rxe_no_col_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    pkt_end && rx_dv && col && !clr2 |=> $stable(rxe_val));

  assert_rxe_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    rxe_val == FULL && !clr2 |=> rxe_val == FULL);

  assert_clr_disc_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    clr0 |=> disc_val == '0);

  assert_clr_fc_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    clr1 |=> fc_val == '0);

  assert_clr_rxe_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    clr2 |=> rxe_val == '0);
endmodule

bind phy_evt_counters phy_evt_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .link_drop(link_drop), .rx_dv(rx_dv),
  .col(col), .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .disc_val(disc_cnt), .fc_val(fcar_cnt), .rxe_val(rxe_cnt)
);

// File: tb/sim_phy_evt_counters.sv
module sim_phy_evt_counters;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, disc, crs, jk, dv, er, col, eop, wr;
  logic [1:0]  addr;
  logic [15:0] rd0;
  logic [3:0]  rd1;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phy_evt_counters u0 (
    .clk(clk), .rst_n(rst_n), .link_drop(disc), .crs(crs), .jk_seen(jk),
    .rx_dv(dv), .rx_er(er), .col(col), .pkt_end(eop),
    .reg_addr(addr), .reg_wr(wr), .rd_data(rd0)
  );

  phy_evt_counters #(.CNT_W(4), .CAR_WIN(3)) u1 (
    .clk(clk), .rst_n(rst_n), .link_drop(disc), .crs(crs), .jk_seen(jk),
    .rx_dv(dv), .rx_er(er), .col(col), .pkt_end(eop),
    .reg_addr(addr), .reg_wr(wr), .rd_data(rd1)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_big(input logic [1:0] a, input string req, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rd0, exp);
  endtask

  task automatic rd_small(input logic [1:0] a, input string req, input logic [3:0] exp);
    addr = a;
    #1;
    check(req, {12'h0, rd1}, {12'h0, exp});
  endtask

  task automatic clear_all();
    for (int i = 0; i < 3; i++) begin
      addr = 2'(i);
      wr   = 1'b1;
      tick();
      wr   = 1'b0;
    end
  endtask

  // dv high for len cycles, pkt_end on the last one, then one idle cycle
  task automatic send_pkt(input int len, input logic [15:0] err_m, input logic [15:0] col_m);
    for (int i = 0; i < len; i++) begin
      dv  = 1'b1;
      er  = err_m[i];
      col = col_m[i];
      eop = (i == len - 1);
      tick();
    end
    dv = 1'b0; er = 1'b0; col = 1'b0; eop = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rd_big(2'd0, "R1 disc after reset", 16'h0);
    rd_big(2'd1, "R1 fcar after reset", 16'h0);
    rd_big(2'd2, "R1 rxerr after reset", 16'h0);
  endtask

  task automatic t_disc();
    clear_all();
    disc = 1'b1; tick(); disc = 1'b0;
    rd_big(2'd0, "R2 single pulse", 16'h1);
    tick();
    disc = 1'b1; tick(); tick(); disc = 1'b0;
    rd_big(2'd0, "R2 consecutive pulses", 16'h3);
  endtask

  task automatic t_wrap();
    clear_all();
    disc = 1'b1; repeat (15) tick(); disc = 1'b0;
    rd_small(2'd0, "R3 reach max", 4'hF);
    disc = 1'b1; tick(); disc = 1'b0;
    rd_small(2'd0, "R3 wrap to zero", 4'h0);
  endtask

  task automatic t_fcar();
    clear_all();
    crs = 1'b1;
    repeat (7) tick();
    rd_big(2'd1, "R4 not before window end", 16'h0);
    tick();
    rd_big(2'd1, "R4 counted at window end", 16'h1);
    crs = 1'b0; repeat (2) tick();
  endtask

  task automatic t_fcar_jk();
    clear_all();
    crs = 1'b1;
    repeat (7) tick();
    jk = 1'b1; tick(); jk = 1'b0;
    repeat (4) tick();
    rd_big(2'd1, "R5 jk on last window cycle", 16'h0);
    crs = 1'b0; tick();
    crs = 1'b1; jk = 1'b1; tick(); jk = 1'b0;
    repeat (10) tick();
    rd_big(2'd1, "R5 jk on rising cycle", 16'h0);
    crs = 1'b0; repeat (2) tick();
  endtask

  task automatic t_fcar_sat();
    clear_all();
    for (int k = 0; k < 17; k++) begin
      crs = 1'b1; repeat (4) tick();
      crs = 1'b0; repeat (2) tick();
    end
    rd_small(2'd1, "R6 false carrier holds at max", 4'hF);
  endtask

  task automatic t_rxerr();
    clear_all();
    send_pkt(6, 16'h0004, 16'h0);
    rd_big(2'd2, "R7 one error packet", 16'h1);
    send_pkt(8, 16'h002A, 16'h0);
    rd_big(2'd2, "R7 many errors count once", 16'h2);
    dv = 1'b1; er = 1'b1; tick(); er = 1'b0; tick();
    rd_big(2'd2, "R8 no count mid packet", 16'h2);
    eop = 1'b1; tick(); eop = 1'b0; dv = 1'b0;
    rd_big(2'd2, "R8 count at packet end", 16'h3);
    tick();
  endtask

  task automatic t_rxerr_col();
    clear_all();
    send_pkt(5, 16'h0002, 16'h0008);
    rd_big(2'd2, "R9 collision packet skipped", 16'h0);
    send_pkt(5, 16'h0, 16'h0);
    rd_big(2'd2, "R13 flags restart on new packet", 16'h0);
    er = 1'b1; col = 1'b1; repeat (2) tick(); er = 1'b0; col = 1'b0;
    send_pkt(4, 16'h0, 16'h0);
    rd_big(2'd2, "R13 error outside packet ignored", 16'h0);
    send_pkt(4, 16'h0008, 16'h0);
    rd_big(2'd2, "R13 error on last cycle counted", 16'h1);
  endtask

  task automatic t_rxerr_sat();
    clear_all();
    for (int k = 0; k < 17; k++) send_pkt(3, 16'h0002, 16'h0);
    rd_small(2'd2, "R10 rx error holds at max", 4'hF);
  endtask

  task automatic t_clear_map();
    clear_all();
    disc = 1'b1; tick(); tick(); disc = 1'b0;
    crs = 1'b1; repeat (9) tick(); crs = 1'b0; tick();
    send_pkt(3, 16'h0001, 16'h0);
    rd_big(2'd0, "R12 address 0 is disconnect", 16'h2);
    rd_big(2'd1, "R12 address 1 is false carrier", 16'h1);
    rd_big(2'd2, "R12 address 2 is rx error", 16'h1);
    rd_big(2'd3, "R12 address 3 reads zero", 16'h0);
    addr = 2'd1; wr = 1'b1; tick(); wr = 1'b0;
    rd_big(2'd1, "R11 selected counter cleared", 16'h0);
    rd_big(2'd0, "R11 other counter kept (disc)", 16'h2);
    rd_big(2'd2, "R11 other counter kept (rxerr)", 16'h1);
    addr = 2'd0; wr = 1'b1; disc = 1'b1; tick(); wr = 1'b0; disc = 1'b0;
    rd_big(2'd0, "R11 clear wins over increment", 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disc = 1'b0; crs = 1'b0; jk = 1'b0; dv = 1'b0;
    er = 1'b0; col = 1'b0; eop = 1'b0; wr = 1'b0; addr = 2'd0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_disc();
    t_wrap();
    t_fcar();
    t_fcar_jk();
    t_fcar_sat();
    t_rxerr();
    t_rxerr_col();
    t_rxerr_sat();
    t_clear_map();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule